// File: doc/BRIEF.md
# Frame-Start Chip-Select Window Generator

This block turns a time-division multiplexed audio serial stream into something an SPI-style receiver can accept. It watches two asynchronous inputs, a frame-start strobe and a bit clock, and drives an active-low chip-select. A rising edge on the frame-start input asserts the select. The select then stays asserted for a programmed number of bit-clock rising edges and is released on the last one. The bit clock and the serial data are not regenerated. They are forwarded combinationally to the SPI clock and data outputs.

Both asynchronous inputs are sampled by a faster system clock. Each passes through a two-flop synchronizer and a rising-edge detector, which turns one input edge into exactly one single-cycle pulse. A 16-bit counter counts bit-clock pulses only while the select is asserted. A second frame start that arrives inside an open window restarts it. A sticky flag reports bit-clock rising edges that are too close together to be counted reliably.

Top module: `fscs_window`

## Requirements
- R1: After reset, `cs_n` is 1 and `spacing_err` is 0.
- R2: A rising edge on `fs_in` drives `cs_n` to 0 and clears the bit counter. `cs_n` reaches 0 within three system-clock cycles of the input edge.
- R3: While `cs_n` is 0, each rising edge of `bclk_in` advances the counter by one. The edge that brings the count equal to `cmp_val` returns `cs_n` to 1. As a result, `cs_n` stays 0 for exactly `cmp_val` bit-clock rising edges, which is checked with values 10 and 128.
- R4: Bit-clock edges that arrive while `cs_n` is 1 are ignored, and `cs_n` stays 1.
- R5: A rising edge on `fs_in` while `cs_n` is already 0 restarts the window. `cs_n` stays 0 and a full `cmp_val` edges are again required to close it.
- R6: When a frame-start pulse and a bit-clock pulse fall in the same system cycle, the frame start wins and that bit-clock edge is not counted.
- R7: `spi_clk_out` always equals `bclk_in` and `spi_data_out` always equals `sdata_in`, with no delay through a register.
- R8: A single bit-clock edge counts exactly once, however long the clock stays high or low afterwards.
- R9: If two synchronized bit-clock rising edges are fewer than MIN_GAP system cycles apart (default 3), `spacing_err` goes to 1. It then stays at 1 until reset. Edges spaced MIN_GAP or more cycles apart never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_val | input | 16 | Number of bit-clock edges in one window |
| fs_in | input | 1 | Asynchronous frame-start strobe |
| bclk_in | input | 1 | Asynchronous serial bit clock |
| sdata_in | input | 1 | Serial data |
| spi_clk_out | output | 1 | Forwarded bit clock |
| spi_data_out | output | 1 | Forwarded serial data |
| cs_n | output | 1 | Active-low chip-select window |
| spacing_err | output | 1 | Sticky flag for bit-clock edges that are too close |

## Verification
The frame-start restart and the bit-clock count can land in the same system cycle. To provoke this, the bench raises `fs_in` and `bclk_in` on the same drive edge, so both synchronizers deliver their pulses together. The collision is judged by counting how many further bit-clock edges are needed before `cs_n` returns high. That number must be the full programmed value. If it is one fewer, the colliding edge was counted.

// File: rtl/fscs_pkg.sv
package fscs_pkg;
    localparam int unsigned CNT_W = 16;

    typedef struct packed {
        logic             cs_n;
        logic [CNT_W-1:0] cnt;
    } win_state_t;
endpackage

// File: rtl/fscs_sync_edge.sv
module fscs_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } se_state_t;

    se_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/fscs_win_ctrl.sv
module fscs_win_ctrl
    import fscs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_rise,
    input  logic             bclk_rise,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             cs_n,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    win_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + ONE;
        if (fs_rise) begin
            st_d.cs_n = 1'b0;
            st_d.cnt  = '0;
        end else if (!st_q.cs_n && bclk_rise) begin
            st_d.cnt = cnt_inc;
            if (cnt_inc == cmp_val) st_d.cs_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_n <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n = st_q.cs_n;
    assign cnt  = st_q.cnt;
endmodule

// File: rtl/fscs_gap_mon.sv
module fscs_gap_mon #(
    parameter int unsigned MIN_GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic err
);
    localparam int unsigned GW = $clog2(MIN_GAP + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(MIN_GAP);
    localparam logic [GW-1:0] GAP_ONE = GW'(1);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic          err;
    } gm_state_t;

    gm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pulse) begin
            if (st_q.gap < GAP_MAX) st_d.err = 1'b1;
            st_d.gap = GAP_ONE;
        end else if (st_q.gap < GAP_MAX) begin
            st_d.gap = st_q.gap + GAP_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gap <= GAP_MAX;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err = st_q.err;
endmodule

// File: rtl/fscs_window.sv
module fscs_window
    import fscs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_GAP     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             fs_in,
    input  logic             bclk_in,
    input  logic             sdata_in,
    output logic             spi_clk_out,
    output logic             spi_data_out,
    output logic             cs_n,
    output logic             spacing_err
);
    logic             fs_rise;
    logic             bclk_rise;
    logic [CNT_W-1:0] cnt;

    fscs_sync_edge #(.STAGES(SYNC_STAGES)) u_fs_sync (
        .clk(clk), .rst_n(rst_n), .async_in(fs_in), .rise_o(fs_rise)
    );

    fscs_sync_edge #(.STAGES(SYNC_STAGES)) u_bclk_sync (
        .clk(clk), .rst_n(rst_n), .async_in(bclk_in), .rise_o(bclk_rise)
    );

    fscs_win_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .fs_rise(fs_rise), .bclk_rise(bclk_rise),
        .cmp_val(cmp_val), .cs_n(cs_n), .cnt(cnt)
    );

    fscs_gap_mon #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk(clk), .rst_n(rst_n), .pulse(bclk_rise), .err(spacing_err)
    );

    assign spi_clk_out  = bclk_in;
    assign spi_data_out = sdata_in;
endmodule

// File: rtl/fscs_window_chk.sv
module fscs_window_chk
    import fscs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             fs_rise,
    input logic             bclk_rise,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_val,
    input logic             cs_n,
    input logic             spacing_err,
    input logic             bclk_in,
    input logic             sdata_in,
    input logic             spi_clk_out,
    input logic             spi_data_out
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_FS_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        fs_rise |=> (!cs_n && cnt == '0)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && bclk_rise && !fs_rise) |=> (cnt == $past(cnt) + ONE)); // R3

    AST_CLOSE_AT_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && bclk_rise && !fs_rise && (cnt + ONE == cmp_val)) |=> cs_n); // R3

    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !fs_rise) |=> (cs_n && $stable(cnt))); // R4

    AST_FS_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_rise && bclk_rise) |=> (cnt == '0)); // R6

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_rise |=> !bclk_rise); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        spacing_err |=> spacing_err); // R9

    always_comb begin
        AST_PASS_THROUGH: assert ((spi_clk_out === bclk_in) && (spi_data_out === sdata_in)); // R7
    end
endmodule

bind fscs_window fscs_window_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fs_rise(fs_rise), .bclk_rise(bclk_rise),
    .cnt(cnt), .cmp_val(cmp_val), .cs_n(cs_n), .spacing_err(spacing_err),
    .bclk_in(bclk_in), .sdata_in(sdata_in), .spi_clk_out(spi_clk_out),
    .spi_data_out(spi_data_out)
);

// File: tb/tb_fscs_window.sv
module tb_fscs_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cmp_val = 16'd10;
    logic        fs_in = 1'b0;
    logic        bclk_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic        spi_clk_out, spi_data_out, cs_n, spacing_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fscs_window dut (
        .clk(clk), .rst_n(rst_n), .cmp_val(cmp_val), .fs_in(fs_in),
        .bclk_in(bclk_in), .sdata_in(sdata_in), .spi_clk_out(spi_clk_out),
        .spi_data_out(spi_data_out), .cs_n(cs_n), .spacing_err(spacing_err)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bclk_pulse(input int hi, input int lo);
        bclk_in = 1'b1;
        wait_n(hi);
        bclk_in = 1'b0;
        wait_n(lo);
    endtask

    task automatic frame_start();
        fs_in = 1'b1;
        wait_n(4);
        chk("R2 select asserted", cs_n, 1'b0);
        fs_in = 1'b0;
        wait_n(2);
    endtask

    // R3 / R8: count n edges, expecting release on edge n
    task automatic count_edges(input string req, input int n, input int hi, input int lo);
        for (int i = 1; i <= n; i++) begin
            bclk_in = 1'b1;
            wait_n(hi);
            chk(req, cs_n, (i < n) ? 1'b0 : 1'b1);
            bclk_in = 1'b0;
            wait_n(lo);
        end
    endtask

    task automatic test_reset();
        chk("R1 cs_n idle", cs_n, 1'b1);
        chk("R1 err clear", spacing_err, 1'b0);
    endtask

    task automatic test_window(input int n);
        cmp_val = 16'(n);
        frame_start();
        count_edges("R3 window length", n, 4, 4);
        for (int i = 0; i < 3; i++) bclk_pulse(4, 4);
        chk("R4 idle edges ignored", cs_n, 1'b1);
    endtask

    task automatic test_restart();
        cmp_val = 16'd10;
        frame_start();
        for (int i = 0; i < 5; i++) bclk_pulse(4, 4);
        chk("R5 still open before restart", cs_n, 1'b0);
        frame_start();
        count_edges("R5 full window after restart", 10, 4, 4);
    endtask

    task automatic test_collision();
        cmp_val = 16'd6;
        fs_in   = 1'b1;
        bclk_in = 1'b1;
        wait_n(4);
        chk("R6 select opened on tie", cs_n, 1'b0);
        fs_in   = 1'b0;
        bclk_in = 1'b0;
        wait_n(4);
        count_edges("R6 tied edge not counted", 6, 4, 4);
    endtask

    task automatic test_long_high();
        cmp_val = 16'd5;
        frame_start();
        count_edges("R8 one count per edge", 5, 20, 3);
    endtask

    task automatic test_pass();
        for (int i = 0; i < 4; i++) begin
            bclk_in  = i[0];
            sdata_in = i[1];
            #1;
            chk("R7 clock forwarded", spi_clk_out, i[0]);
            chk("R7 data forwarded", spi_data_out, i[1]);
        end
        bclk_in  = 1'b0;
        sdata_in = 1'b0;
        wait_n(4);
    endtask

    task automatic test_spacing();
        chk("R9 no error on legal spacing", spacing_err, 1'b0);
        for (int i = 0; i < 8; i++) begin
            bclk_in = ~bclk_in;
            wait_n(1);
        end
        bclk_in = 1'b0;
        wait_n(4);
        chk("R9 error on close edges", spacing_err, 1'b1);
        for (int i = 0; i < 3; i++) bclk_pulse(4, 4);
        chk("R9 error sticky", spacing_err, 1'b1);
    endtask

    initial begin
        wait_n(3);
        test_reset();
        rst_n = 1'b1;
        wait_n(3);
        test_reset();
        test_window(10);
        test_window(128);
        test_restart();
        test_collision();
        test_long_high();
        test_pass();
        test_spacing();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule